// File: doc/BRIEF.md
# T1 to 2.048 MHz Backplane Mapper

This block takes the bytes of a received T1 frame (24 eight-bit channels and one framing bit, 193 bits in all) from an elastic store. It lays them out on a 2.048 MHz serial backplane whose frame is 32 eight-bit timeslots. Every fourth timeslot, counted from 0, is filler and carries no channel. The 24 remaining timeslots carry T1 channels 1 to 24 in ascending order. The framing bit rides in the first bit of filler timeslot 0. For each timeslot it produces the serial data, a channel clock, a channel-block marker and a frame sync.

The block reads one byte from the store just before each channel timeslot, and one byte for the framing bit just before timeslot 0. It uses a single-cycle request with the channel index; the store answers combinationally in that cycle. A mode input selects the sync direction. In drive mode the block emits a one-bit sync pulse at the start of each backplane frame. In align mode the block listens to the sync input, and a rising edge restarts the frame. The block runs on the 2.048 MHz bit clock. Its reset is asserted asynchronously and released two clocks after the reset input rises.

Top module: `t1_bp_mapper`

## Requirements
- R1: A backplane frame is 32 timeslots of 8 bit clocks (256 clocks). In drive mode (`sync_in_mode`=0), `sync_o` is high only for the first bit clock of timeslot 0 and `sync_oe` is high.
- R2: In filler timeslots (0-based slot numbers where slot mod 4 = 0: 0, 4, 8, ..., 28), `ser_o` is 1 on every bit. The single exception is bit 0 of slot 0, which carries the framing bit.
- R3: `blk_o` is high for all 8 bits of every filler timeslot and low in every other timeslot.
- R4: `chclk_o` is high during bits 0 to 3 of each channel timeslot and low otherwise, so it has no rising edge inside a filler timeslot.
- R5: Channel timeslot s carries T1 channel s - floor(s/4), which runs 1 to 24 in slot order. The byte is the one the store returned for `rd_chan` equal to that channel number, sent MSB first (bit 7 in bit clock 0).
- R6: The byte read with `rd_chan`=0 holds the framing bit in bit 7. That bit appears on `ser_o` in bit 0 of slot 0 of the following frame start.
- R7: `rd_req` is high for exactly one clock: the last clock before each channel timeslot and before slot 0. No request is made ahead of other filler slots. The block captures `rd_data` on the clock edge that ends the request cycle.
- R8: In align mode (`sync_in_mode`=1), `sync_oe` is low, `sync_o` is low, and the frame counter free-runs until a rising edge occurs on `sync_i`.
- R9: In align mode, when `sync_i` is sampled high on an edge after being sampled low on the previous edge, the timing restarts at slot 0 bit 0 after that edge. A read for slot 0 is requested in the same cycle. Holding `sync_i` high causes no further restart.
- R10: While reset is applied, and for two clocks after `rst_n` rises, the block sits at slot 0 bit 0. In that state `blk_o`=1, `chclk_o`=0 and `rd_req`=0, and in drive mode `sync_o`=1 and `sync_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in_mode | input | 1 | 0: drive frame sync, 1: align to sync_i |
| sync_i | input | 1 | Frame sync input used in align mode |
| rd_data | input | 8 | Store byte for the requested channel |
| rd_req | output | 1 | Store read request |
| rd_chan | output | 5 | Requested channel, 0 = framing bit entry |
| ser_o | output | 1 | Backplane serial data |
| chclk_o | output | 1 | Per-timeslot channel clock |
| blk_o | output | 1 | Channel-block marker for filler timeslots |
| sync_o | output | 1 | Frame sync output value |
| sync_oe | output | 1 | Output enable for the sync pin |

## Verification
The bench builds the block with its default parameters: 32 timeslots of 8 bits and a filler stride of 4, giving 24 channel slots. With these values every frame covers all eight filler slots, including the shared framing-bit slot, and all 24 channel positions. The store pattern changes each frame, so an off-by-one in channel order or frame order shows up as wrong bytes. The same build also reaches a realignment in the middle of a filler slot, a realignment in the middle of a channel slot, and a long high level on the sync input.

// File: rtl/bp_map_pkg.sv
package bp_map_pkg;

  typedef enum logic {
    SYNC_DRIVE = 1'b0,
    SYNC_ALIGN = 1'b1
  } sync_dir_e;

  function automatic logic slot_is_filler(int unsigned s, int unsigned stride);
    return (s % stride) == 0;
  endfunction

  function automatic int unsigned slot_chan(int unsigned s, int unsigned stride);
    if (slot_is_filler(s, stride)) return 0;
    return s - (s / stride);
  endfunction

endpackage

// File: rtl/bp_frame_timer.sv
module bp_frame_timer
  import bp_map_pkg::*;
#(
  parameter int N_SLOTS   = 32,
  parameter int SLOT_BITS = 8,
  localparam int SLOT_W   = $clog2(N_SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in_mode,
  input  logic              sync_i,
  output logic [SLOT_W-1:0] slot_q,
  output logic [BIT_W-1:0]  bit_q,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic [BIT_W-1:0]  nxt_bit,
  output logic              sync_o,
  output logic              sync_oe
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);

  sync_dir_e dir;
  logic      sync_prev_q;
  logic      rise;

  assign dir = sync_dir_e'(sync_in_mode);

  // next-state
  always_comb begin
    rise     = (dir == SYNC_ALIGN) && sync_i && !sync_prev_q;
    nxt_slot = slot_q;
    nxt_bit  = bit_q;
    if (rise) begin
      nxt_slot = '0;
      nxt_bit  = '0;
    end else if (bit_q == LAST_BIT) begin
      nxt_bit  = '0;
      nxt_slot = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end else begin
      nxt_bit  = bit_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q      <= '0;
      bit_q       <= '0;
      sync_prev_q <= 1'b0;
    end else begin
      slot_q      <= nxt_slot;
      bit_q       <= nxt_bit;
      sync_prev_q <= sync_i;
    end
  end

  assign sync_oe = (dir == SYNC_DRIVE);
  assign sync_o  = (dir == SYNC_DRIVE) && (slot_q == '0) && (bit_q == '0);

endmodule

// File: rtl/bp_slot_decode.sv
module bp_slot_decode
  import bp_map_pkg::*;
#(
  parameter int N_SLOTS     = 32,
  parameter int FILL_STRIDE = 4,
  parameter int SLOT_W      = $clog2(N_SLOTS),
  parameter int CHAN_W      = 5
) (
  input  logic [SLOT_W-1:0] slot,
  output logic              filler,
  output logic [CHAN_W-1:0] chan
);

  always_comb begin
    filler = slot_is_filler(int'(slot), FILL_STRIDE);
    chan   = CHAN_W'(slot_chan(int'(slot), FILL_STRIDE));
  end

endmodule

// File: rtl/bp_serializer.sv
module bp_serializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  output logic         msb
);

  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load_en)       sh_d = load_val;
    else if (shift_en) sh_d = {sh_q[W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign msb = sh_q[W-1];

endmodule

// File: rtl/t1_bp_mapper.sv
module t1_bp_mapper #(
  parameter int N_SLOTS     = 32,
  parameter int SLOT_BITS   = 8,
  parameter int FILL_STRIDE = 4,
  localparam int SLOT_W     = $clog2(N_SLOTS),
  localparam int BIT_W      = $clog2(SLOT_BITS),
  localparam int N_CHAN     = N_SLOTS - N_SLOTS / FILL_STRIDE,
  localparam int CHAN_W     = $clog2(N_CHAN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_in_mode,
  input  logic                 sync_i,
  input  logic [SLOT_BITS-1:0] rd_data,
  output logic                 rd_req,
  output logic [CHAN_W-1:0]    rd_chan,
  output logic                 ser_o,
  output logic                 chclk_o,
  output logic                 blk_o,
  output logic                 sync_o,
  output logic                 sync_oe
);

  // reset: asynchronous assert, two-flop synchronous release
  logic rst_m_q;
  logic rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q    <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_m_q    <= 1'b1;
      rst_core_n <= rst_m_q;
    end
  end

  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;
  logic [SLOT_W-1:0] nxt_slot;
  logic [BIT_W-1:0]  nxt_bit;

  bp_frame_timer #(
    .N_SLOTS  (N_SLOTS),
    .SLOT_BITS(SLOT_BITS)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .sync_in_mode(sync_in_mode),
    .sync_i      (sync_i),
    .slot_q      (slot_q),
    .bit_q       (bit_q),
    .nxt_slot    (nxt_slot),
    .nxt_bit     (nxt_bit),
    .sync_o      (sync_o),
    .sync_oe     (sync_oe)
  );

  // slot decoders: index 0 = current slot, index 1 = next slot
  logic [SLOT_W-1:0] dec_slot [2];
  logic              dec_fill [2];
  logic [CHAN_W-1:0] dec_chan [2];

  assign dec_slot[0] = slot_q;
  assign dec_slot[1] = nxt_slot;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    bp_slot_decode #(
      .N_SLOTS    (N_SLOTS),
      .FILL_STRIDE(FILL_STRIDE),
      .SLOT_W     (SLOT_W),
      .CHAN_W     (CHAN_W)
    ) u_dec (
      .slot  (dec_slot[g]),
      .filler(dec_fill[g]),
      .chan  (dec_chan[g])
    );
  end

  logic cur_fill;
  logic nxt_fill;
  logic fpos;
  logic sh_msb;

  assign cur_fill = dec_fill[0];
  assign nxt_fill = dec_fill[1];

  // store read: one cycle ahead of each channel slot and of slot 0
  assign rd_req  = (nxt_bit == '0) && (!nxt_fill || (nxt_slot == '0));
  assign rd_chan = dec_chan[1];

  bp_serializer #(
    .W(SLOT_BITS)
  ) u_ser (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load_en (rd_req),
    .load_val(rd_data),
    .shift_en(1'b1),
    .msb     (sh_msb)
  );

  assign fpos    = cur_fill && (slot_q == '0) && (bit_q == '0);
  assign ser_o   = (cur_fill && !fpos) ? 1'b1 : sh_msb;
  assign blk_o   = cur_fill;
  assign chclk_o = !cur_fill && (bit_q < BIT_W'(SLOT_BITS / 2));

endmodule

// File: rtl/bp_mapper_chk.sv
module bp_mapper_chk #(
  parameter int N_SLOTS   = 32,
  parameter int SLOT_BITS = 8,
  localparam int SLOT_W   = $clog2(N_SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              sync_in_mode,
  input logic              sync_i,
  input logic              rd_req,
  input logic              ser_o,
  input logic              chclk_o,
  input logic              blk_o,
  input logic              sync_o,
  input logic              sync_oe,
  input logic [SLOT_W-1:0] slot_q,
  input logic [BIT_W-1:0]  bit_q
);

  // R1: a drive-mode sync pulse follows the last bit of the last slot
  p_sync_period_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!sync_in_mode && $past(!sync_in_mode) && $past(rst_core_n) && sync_o)
      |-> ($past(slot_q) == SLOT_W'(N_SLOTS - 1) && $past(bit_q) == BIT_W'(SLOT_BITS - 1)));

  // R1: bit counter steps by one inside a slot when not aligning
  p_bit_step_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!sync_in_mode && bit_q != BIT_W'(SLOT_BITS - 1)) |=> (bit_q == $past(bit_q) + 1'b1));

  // R2: filler data high apart from the framing-bit position
  p_filler_ones_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (blk_o && !(slot_q == '0 && bit_q == '0)) |-> ser_o);

  // R3: marker and channel clock never high together
  p_blk_excl_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    blk_o |-> !chclk_o);

  // R4: channel clock rises only at bit 0 of a channel slot
  p_clk_rise_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(chclk_o) |-> (bit_q == '0 && !blk_o));

  // R7: a read request always precedes bit 0 of a slot
  p_req_slot_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_req |=> (bit_q == '0));

  // R8: pin direction follows the mode input
  p_sync_dir_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    sync_in_mode |-> (!sync_oe && !sync_o));

  // R9: rising edge on sync restarts the frame
  p_resync_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sync_in_mode && sync_i && !$past(sync_i) && $past(rst_core_n))
      |=> (slot_q == '0 && bit_q == '0));

endmodule

bind t1_bp_mapper bp_mapper_chk #(
  .N_SLOTS  (N_SLOTS),
  .SLOT_BITS(SLOT_BITS)
) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .sync_in_mode(sync_in_mode),
  .sync_i      (sync_i),
  .rd_req      (rd_req),
  .ser_o       (ser_o),
  .chclk_o     (chclk_o),
  .blk_o       (blk_o),
  .sync_o      (sync_o),
  .sync_oe     (sync_oe),
  .slot_q      (slot_q),
  .bit_q       (bit_q)
);

// File: tb/test_t1_bp_mapper.sv
module test_t1_bp_mapper;

  localparam int CLK_P = 488;

  typedef struct {
    int         ch;
    logic [7:0] b;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_in_mode;
  logic       sync_i;
  logic [7:0] rd_data;
  logic       rd_req;
  logic [4:0] rd_chan;
  logic       ser_o, chclk_o, blk_o, sync_o, sync_oe;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #(CLK_P / 2) clk = ~clk;

  t1_bp_mapper i_t1_bp_mapper (
    .clk(clk), .rst_n(rst_n), .sync_in_mode(sync_in_mode), .sync_i(sync_i),
    .rd_data(rd_data), .rd_req(rd_req), .rd_chan(rd_chan), .ser_o(ser_o),
    .chclk_o(chclk_o), .blk_o(blk_o), .sync_o(sync_o), .sync_oe(sync_oe)
  );

  function automatic logic [7:0] store_byte(int ch, int f);
    return 8'(((ch * 37) + (f * 11) + 3) ^ 90);
  endfunction

  int fr = 0;
  assign rd_data = store_byte(int'(rd_chan), fr);

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d (slot bit state)", req, act, exp);
    end
  endtask

  // bench view of position and the release pipe of the reset
  logic [1:0] rpipe;
  int  tb_slot, tb_bit;
  bit  tb_prev;
  bit  p_rs, p_req;
  int  p_ch, p_ns, p_nb;
  logic [7:0] p_dat;
  item_t q[$];
  item_t cur;
  bit  skip_first;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rpipe <= 2'b00;
    else        rpipe <= {rpipe[0], 1'b1};
  end

  // driver side: applies the position update and pushes expected store items
  always @(posedge clk) begin
    if (!rpipe[1]) begin
      tb_slot    <= 0;
      tb_bit     <= 0;
      tb_prev    <= 1'b0;
      skip_first <= 1'b1;
    end else begin
      tb_slot <= p_ns;
      tb_bit  <= p_nb;
      tb_prev <= sync_i;
      if (p_rs) q.delete();
      if (p_req) begin
        q.push_back('{p_ch, p_dat});
        if (p_ch == 0) fr <= fr + 1;
      end
    end
  end

  // monitor side: checks outputs against the requirements away from the edge
  always @(negedge clk) begin
    int ns, nb, ech;
    bit rs, ereq, fill;
    if (!rpipe[1]) begin
      p_req = 1'b0;
      p_rs  = 1'b0;
      if (rst_n !== 1'bx) begin
        chk(blk_o === 1'b1, "R10 blk", int'(blk_o), 1);
        chk(chclk_o === 1'b0, "R10 chclk", int'(chclk_o), 0);
        chk(rd_req === 1'b0, "R10 rd_req", int'(rd_req), 0);
        if (!sync_in_mode) chk(sync_o === 1'b1 && sync_oe === 1'b1, "R10 sync", int'(sync_o), 1);
      end
    end else begin
      rs = sync_in_mode && sync_i && !tb_prev;
      if (rs) begin ns = 0; nb = 0; end
      else begin
        nb = tb_bit + 1; ns = tb_slot;
        if (nb == 8) begin nb = 0; ns = (tb_slot + 1) % 32; end
      end
      ereq = (nb == 0) && ((ns % 4) != 0 || ns == 0);
      ech  = ((ns % 4) == 0) ? 0 : ns - ns / 4;
      chk(rd_req === ereq, "R7 rd_req", int'(rd_req), int'(ereq));
      if (ereq) chk(int'(rd_chan) == ech, "R5 rd_chan", int'(rd_chan), ech);
      p_rs = rs; p_req = rd_req; p_ch = int'(rd_chan); p_dat = rd_data;
      p_ns = ns; p_nb = nb;

      fill = (tb_slot % 4) == 0;
      chk(blk_o === fill, "R3 blk", int'(blk_o), int'(fill));
      chk(chclk_o === (!fill && tb_bit < 4), "R4 chclk", int'(chclk_o), int'(!fill && tb_bit < 4));
      if (!sync_in_mode)
        chk(sync_oe === 1'b1 && sync_o === (tb_slot == 0 && tb_bit == 0), "R1 sync_o",
            int'(sync_o), int'(tb_slot == 0 && tb_bit == 0));
      else
        chk(sync_oe === 1'b0 && sync_o === 1'b0, "R8 sync pin", int'(sync_oe), 0);

      if (tb_bit == 0 && (!fill || tb_slot == 0)) begin
        if (tb_slot == 0 && skip_first) begin
          skip_first = 1'b0;
          cur = '{-1, 8'h00};
        end else if (q.size() == 0) begin
          chk(1'b0, "R7 missing read", 0, 1);
          cur = '{-1, 8'h00};
        end else begin
          cur = q.pop_front();
          chk(cur.ch == (fill ? 0 : tb_slot - tb_slot / 4), "R5 order", cur.ch,
              fill ? 0 : tb_slot - tb_slot / 4);
        end
      end
      if (fill && !(tb_slot == 0 && tb_bit == 0))
        chk(ser_o === 1'b1, "R2 filler", int'(ser_o), 1);
      else if (cur.ch >= 0) begin
        if (fill) chk(ser_o === cur.b[7], "R6 fbit", int'(ser_o), int'(cur.b[7]));
        else      chk(ser_o === cur.b[7 - tb_bit], "R5 data", int'(ser_o), int'(cur.b[7 - tb_bit]));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_pos(int s, int b);
    do step(1); while (!(tb_slot == s && tb_bit == b));
  endtask

  initial begin
    rst_n = 1'b0; sync_in_mode = 1'b0; sync_i = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(3 * 256 + 10);                 // drive mode, R1..R7
    sync_in_mode = 1'b1;                // R8 free-run in align mode
    step(100);
    wait_pos(12, 4);                    // R9 realign mid filler slot
    sync_i = 1'b1;
    step(300);                          // held high: no further restart
    sync_i = 1'b0;
    step(200);
    wait_pos(6, 3);                     // R9 realign mid channel slot
    sync_i = 1'b1;
    step(1);
    sync_i = 1'b0;
    step(600);
    sync_in_mode = 1'b0;
    step(520);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

endmodule